// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This peripheral sits on a simple synchronous register bus and provides two 8-bit general-purpose ports, A and B. Each port has an output latch, a per-bit direction register and a control register. Each port also has two side lines. The first side line (C1) is always an edge-detecting input. The second side line (C2) is either a second edge input or an output. As an output it can run a handshake, emit a one-clock strobe or hold a level set by software.

Active edges on the side lines set sticky flags that software sees in the top two bits of the port's control register. Each port drives its own active-low interrupt line. The handshakes are deliberately asymmetric so that a receiving port A and a transmitting port B can be wired back to back. Port A completes its handshake when software reads the data. Port B completes its handshake when software writes the data.

Top module: `pia_dual_port`

## Requirements
- R1: After reset all registers are zero. Both ports are then inputs, offsets 0 and 2 reach the direction registers, both interrupt outputs are high and both C2 output enables are low.
- R2: Offset 1 is port A control and offset 3 is port B control. Offsets 0 and 2 reach port A and port B data when control bit 2 is 1, and the direction register when it is 0. A direction bit of 1 makes that pin an output.
- R3: Reading a data register returns the pin level for input bits and the output latch for output bits. The port output pins always show the latch.
- R4: Control bit 7 is set one clock after an active C1 edge. Control bit 1 chooses the active edge: 1 for rising, 0 for falling. Control bit 0 enables the C1 interrupt.
- R5: With control bit 5 at 0, C2 is an input. Bit 4 chooses its active edge (1 rising, 0 falling), bit 3 enables its interrupt and bit 6 is its flag, set one clock after the edge.
- R6: A read of a port's data register clears bits 7 and 6 of that port. An active edge sampled in the same cycle as the read keeps its flag set.
- R7: Control bits 7 and 6 ignore bus writes. A write changes only bits 5 to 0.
- R8: Each interrupt output is low exactly while its port has a flag set whose enable is on. The C2 flag counts only in input mode.
- R9: Port A handshake (control bits 5..3 = 100): CA2 goes high one clock after an active CA1 edge and low one clock after a data read. A write has no effect on it. An edge and a read in the same cycle leave it high. Its state after reset is low.
- R10: Port B handshake (bits 5..3 = 100): CB2 goes high one clock after an active CB1 edge and low one clock after a data write. A read has no effect on it.
- R11: Pulse mode (bits 5..3 = 101): C2 is low for exactly the one clock following the port A data read (or port B data write), and high otherwise.
- R12: Manual mode (bits 5..4 = 11): C2 equals control bit 3. The C2 output enable equals control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select for the current bus cycle |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (data reads have side effects) |
| addr | input | 2 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr |
| paIn | input | 8 | Port A pin levels |
| paOut | output | 8 | Port A output latch |
| paDir | output | 8 | Port A direction (1 = drive) |
| ca1 | input | 1 | Port A edge input |
| ca2In | input | 1 | Port A second line, input side |
| ca2Out | output | 1 | Port A second line, output value |
| ca2OutEn | output | 1 | Port A second line, output enable |
| irqAN | output | 1 | Port A interrupt, active low |
| pbIn | input | 8 | Port B pin levels |
| pbOut | output | 8 | Port B output latch |
| pbDir | output | 8 | Port B direction (1 = drive) |
| cb1 | input | 1 | Port B edge input |
| cb2In | input | 1 | Port B second line, input side |
| cb2Out | output | 1 | Port B second line, output value |
| cb2OutEn | output | 1 | Port B second line, output enable |
| irqBN | output | 1 | Port B interrupt, active low |

## Verification
The two functions that can collide are the active-edge capture on a side line and the data-register read that clears the flags and ends the port A handshake. The bench provokes both in one bus cycle: it toggles CA1 and asserts a data read before the same clock edge. It does this once with CA2 in handshake mode and once with only the flag enabled. A behavioural model gives the edge priority, so the flag and CA2 must read high afterwards. The model is compared with every output on every clock.

// File: rtl/pia_pkg.sv
package pia_pkg;
  // Bus strobes produced by the decoder for one port
  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic wrCtrl;
    logic rdData;
  } portStrobe_t;

  localparam int CTRL_W       = 8;
  localparam int CFG_W        = 6;
  localparam int FLAG1_BIT    = 7;
  localparam int FLAG2_BIT    = 6;
  localparam int C2_OUT_BIT   = 5;
  localparam int C2_MODE_BIT  = 4;
  localparam int C2_SUB_BIT   = 3;
  localparam int SEL_DATA_BIT = 2;
  localparam int C1_EDGE_BIT  = 1;
  localparam int C1_IRQ_BIT   = 0;
endpackage

// File: rtl/pia_decode.sv
module pia_decode
  import pia_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  localparam int AW = $clog2(2 * NUM_PORTS)
) (
  input  logic                 sel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [AW-1:0]        addr,
  input  logic [NUM_PORTS-1:0] selData,
  output portStrobe_t [NUM_PORTS-1:0] strobes
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic isCtrl;
    assign hit    = sel && (addr[AW-1:1] == (AW-1)'(p));
    assign isCtrl = addr[0];
    assign strobes[p].wrDir  = hit && !isCtrl && wrEn && !selData[p];
    assign strobes[p].wrData = hit && !isCtrl && wrEn &&  selData[p];
    assign strobes[p].rdData = hit && !isCtrl && rdEn &&  selData[p];
    assign strobes[p].wrCtrl = hit &&  isCtrl && wrEn;
  end
endmodule

// File: rtl/pia_port.sv
module pia_port
  import pia_pkg::*;
#(
  parameter int W           = 8,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t stb,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] pinIn,
  input  logic        c1,
  input  logic        c2In,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pinDir,
  output logic        c2Out,
  output logic        c2OutEn,
  output logic        irqN,
  output logic        selData,
  output logic [W-1:0] dataView,
  output logic [W-1:0] dirView,
  output logic [W-1:0] ctrlView
);
  logic [W-1:0]     dirQ, latQ;
  logic [CFG_W-1:0] cfgQ;
  logic flag1Q, flag2Q, c1Prev, c2Prev, hsQ, pulseQ;
  logic edge1, edge2, trig;

  assign edge1 = cfgQ[C1_EDGE_BIT] ? (c1 && !c1Prev) : (!c1 && c1Prev);
  assign edge2 = !cfgQ[C2_OUT_BIT] &&
                 (cfgQ[C2_MODE_BIT] ? (c2In && !c2Prev) : (!c2In && c2Prev));

  // The access that completes the handshake differs between the two ports
  if (HS_ON_WRITE) begin : g_hs_wr
    assign trig = stb.wrData;
  end else begin : g_hs_rd
    assign trig = stb.rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      latQ   <= '0;
      cfgQ   <= '0;
      flag1Q <= 1'b0;
      flag2Q <= 1'b0;
      c1Prev <= 1'b0;
      c2Prev <= 1'b0;
      hsQ    <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      c1Prev <= c1;
      c2Prev <= c2In;
      if (edge1)           flag1Q <= 1'b1;
      else if (stb.rdData) flag1Q <= 1'b0;
      if (edge2)           flag2Q <= 1'b1;
      else if (stb.rdData) flag2Q <= 1'b0;
      if (edge1)           hsQ <= 1'b1;
      else if (trig)       hsQ <= 1'b0;
      pulseQ <= trig && (cfgQ[C2_OUT_BIT:C2_SUB_BIT] == 3'b101);
      if (stb.wrDir)  dirQ <= wrData;
      if (stb.wrData) latQ <= wrData;
      if (stb.wrCtrl) cfgQ <= wrData[CFG_W-1:0];
    end
  end

  assign pinOut   = latQ;
  assign pinDir   = dirQ;
  assign selData  = cfgQ[SEL_DATA_BIT];
  assign c2OutEn  = cfgQ[C2_OUT_BIT];
  assign c2Out    = cfgQ[C2_MODE_BIT] ? cfgQ[C2_SUB_BIT]
                  : (cfgQ[C2_SUB_BIT] ? !pulseQ : hsQ);
  assign irqN     = !((flag1Q && cfgQ[C1_IRQ_BIT]) ||
                      (flag2Q && cfgQ[C2_SUB_BIT] && !cfgQ[C2_OUT_BIT]));
  assign dataView = (pinIn & ~dirQ) | (latQ & dirQ);
  assign dirView  = dirQ;
  assign ctrlView = W'({flag1Q, flag2Q, cfgQ});
endmodule

// File: rtl/pia_dual_port.sv
module pia_dual_port
  import pia_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sel,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic [W-1:0] paIn,
  output logic [W-1:0] paOut,
  output logic [W-1:0] paDir,
  input  logic         ca1,
  input  logic         ca2In,
  output logic         ca2Out,
  output logic         ca2OutEn,
  output logic         irqAN,
  input  logic [W-1:0] pbIn,
  output logic [W-1:0] pbOut,
  output logic [W-1:0] pbDir,
  input  logic         cb1,
  input  logic         cb2In,
  output logic         cb2Out,
  output logic         cb2OutEn,
  output logic         irqBN
);
  localparam int NUM_PORTS = 2;

  portStrobe_t [NUM_PORTS-1:0] stb;
  logic [NUM_PORTS-1:0] selData, c1Arr, c2InArr, c2OutArr, c2EnArr, irqArr;
  logic [W-1:0] pinInArr [NUM_PORTS];
  logic [W-1:0] pinOutArr[NUM_PORTS];
  logic [W-1:0] pinDirArr[NUM_PORTS];
  logic [W-1:0] dataView [NUM_PORTS];
  logic [W-1:0] dirView  [NUM_PORTS];
  logic [W-1:0] ctrlView [NUM_PORTS];

  assign pinInArr[0] = paIn;
  assign pinInArr[1] = pbIn;
  assign c1Arr       = {cb1, ca1};
  assign c2InArr     = {cb2In, ca2In};

  pia_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .selData(selData), .strobes(stb)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pia_port #(.W(W), .HS_ON_WRITE(p == 1)) u_port (
      .clk(clk), .rstN(rstN), .stb(stb[p]), .wrData(wrData),
      .pinIn(pinInArr[p]), .c1(c1Arr[p]), .c2In(c2InArr[p]),
      .pinOut(pinOutArr[p]), .pinDir(pinDirArr[p]),
      .c2Out(c2OutArr[p]), .c2OutEn(c2EnArr[p]), .irqN(irqArr[p]),
      .selData(selData[p]), .dataView(dataView[p]),
      .dirView(dirView[p]), .ctrlView(ctrlView[p])
    );
  end

  always_comb begin
    if (addr[0])               rdData = ctrlView[addr[1]];
    else if (selData[addr[1]]) rdData = dataView[addr[1]];
    else                       rdData = dirView[addr[1]];
  end

  assign paOut    = pinOutArr[0];
  assign pbOut    = pinOutArr[1];
  assign paDir    = pinDirArr[0];
  assign pbDir    = pinDirArr[1];
  assign ca2Out   = c2OutArr[0];
  assign cb2Out   = c2OutArr[1];
  assign ca2OutEn = c2EnArr[0];
  assign cb2OutEn = c2EnArr[1];
  assign irqAN    = irqArr[0];
  assign irqBN    = irqArr[1];
endmodule

// File: rtl/pia_dual_port_chk.sv
module pia_dual_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sel,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       ca1,
  input logic       ca2Out,
  input logic       ca2OutEn,
  input logic       cb2Out,
  input logic       irqAN,
  input logic [7:0] ctrlA,
  input logic [7:0] ctrlB
);
  logic wrCtrlA, wrCtrlB, wrDataB;
  assign wrCtrlA = sel && wrEn && (addr == 2'd1);
  assign wrCtrlB = sel && wrEn && (addr == 2'd3);
  assign wrDataB = sel && wrEn && (addr == 2'd2);

  // R12: output enable follows the written direction bit
  p_c2_enable_r12: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlA |=> (ca2OutEn == $past(wrData[5])));

  // R12: manual mode drives the written level
  p_manual_level_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrlA && wrData[5:4] == 2'b11) |=> (ca2Out == $past(wrData[3])));

  // R11: a strobe low lasts a single clock when not retriggered
  p_pulse_width_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlB[5:3] == 3'b101 && !cb2Out && !wrCtrlB && !wrDataB) |=> cb2Out);

  // R8: an asserted interrupt implies some flag of that port
  p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqAN |-> (ctrlA[7] || ctrlA[6]));

  // R4: the C1 flag rises only after the line changed
  p_flag_needs_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlA[7]) |-> ($past(ca1) != $past(ca1, 2)));
endmodule

bind pia_dual_port pia_dual_port_chk chk_i (
  .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .ca1(ca1), .ca2Out(ca2Out), .ca2OutEn(ca2OutEn),
  .cb2Out(cb2Out), .irqAN(irqAN),
  .ctrlA(ctrlView[0]), .ctrlB(ctrlView[1])
);

// File: tb/pia_dual_port_tb_top.sv
module pia_dual_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic sel = 0, wrEn = 0, rdEn = 0;
  logic [1:0] addr = 0;
  logic [7:0] wrData = 0, rdData, paIn = 0, pbIn = 0;
  logic [7:0] paOut, paDir, pbOut, pbDir;
  logic ca1 = 0, ca2In = 0, cb1 = 0, cb2In = 0;
  logic ca2Out, ca2OutEn, cb2Out, cb2OutEn, irqAN, irqBN;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  pia_dual_port dut_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .paIn(paIn), .paOut(paOut), .paDir(paDir), .ca1(ca1), .ca2In(ca2In),
    .ca2Out(ca2Out), .ca2OutEn(ca2OutEn), .irqAN(irqAN),
    .pbIn(pbIn), .pbOut(pbOut), .pbDir(pbDir), .cb1(cb1), .cb2In(cb2In),
    .cb2Out(cb2Out), .cb2OutEn(cb2OutEn), .irqBN(irqBN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  int dirM[2], latM[2], cfgM[2], f1M[2], f2M[2], hsM[2], plM[2], p1M[2], p2M[2];

  function automatic int pinOf(int p);
    return (p == 0) ? int'(paIn) : int'(pbIn);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        dirM[p] = 0; latM[p] = 0; cfgM[p] = 0; f1M[p] = 0; f2M[p] = 0;
        hsM[p] = 0; plM[p] = 0; p1M[p] = 0; p2M[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        int c1v, c2v, e1, e2, wD, wDir, rD, wC, trig;
        bit isData, hitD;
        isData = cfgM[p][2];
        hitD = sel && (int'(addr) == 2 * p);
        wD   = int'(hitD && wrEn && isData);
        wDir = int'(hitD && wrEn && !isData);
        rD   = int'(hitD && rdEn && isData);
        wC   = int'(sel && wrEn && (int'(addr) == 2 * p + 1));
        c1v  = (p == 0) ? int'(ca1) : int'(cb1);
        c2v  = (p == 0) ? int'(ca2In) : int'(cb2In);
        e1 = cfgM[p][1] ? int'(c1v == 1 && p1M[p] == 0) : int'(c1v == 0 && p1M[p] == 1);
        e2 = 0;
        if (!cfgM[p][5])
          e2 = cfgM[p][4] ? int'(c2v == 1 && p2M[p] == 0) : int'(c2v == 0 && p2M[p] == 1);
        trig = (p == 0) ? rD : wD;
        if (e1 != 0) f1M[p] = 1; else if (rD != 0) f1M[p] = 0;
        if (e2 != 0) f2M[p] = 1; else if (rD != 0) f2M[p] = 0;
        if (e1 != 0) hsM[p] = 1; else if (trig != 0) hsM[p] = 0;
        plM[p] = int'(trig != 0 && ((cfgM[p] >> 3) & 7) == 5);
        if (wDir != 0) dirM[p] = int'(wrData);
        if (wD != 0)   latM[p] = int'(wrData);
        if (wC != 0)   cfgM[p] = int'(wrData) & 63;
        p1M[p] = c1v; p2M[p] = c2v;
      end
    end
  end

  function automatic int expRd();
    int p;
    p = int'(addr) >> 1;
    if (addr[0]) return (f1M[p] << 7) | (f2M[p] << 6) | cfgM[p];
    if (cfgM[p][2]) return ((pinOf(p) & ~dirM[p]) | (latM[p] & dirM[p])) & 255;
    return dirM[p];
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare every output with the model on each falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int p = 0; p < 2; p++) begin
        int expIrq, expC2;
        expIrq = int'(!((f1M[p] != 0 && cfgM[p][0]) ||
                        (f2M[p] != 0 && cfgM[p][3] && !cfgM[p][5])));
        expC2 = cfgM[p][4] ? int'(cfgM[p][3]) : (cfgM[p][3] ? int'(plM[p] == 0) : hsM[p]);
        chk("dir", (p == 0) ? int'(paDir) : int'(pbDir), dirM[p]);
        chk("out", (p == 0) ? int'(paOut) : int'(pbOut), latM[p]);
        chk("irq", (p == 0) ? int'(irqAN) : int'(irqBN), expIrq);
        chk("c2en", (p == 0) ? int'(ca2OutEn) : int'(cb2OutEn), int'(cfgM[p][5]));
        if (cfgM[p][5]) chk("c2", (p == 0) ? int'(ca2Out) : int'(cb2Out), expC2);
      end
      chk("rd", int'(rdData), expRd());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic busWr(int a, int d);
    sel = 1; wrEn = 1; addr = 2'(a); wrData = 8'(d);
    idle(1);
    sel = 0; wrEn = 0;
  endtask

  task automatic busRd(int a);
    sel = 1; rdEn = 1; addr = 2'(a);
    #1 chk("rdval", int'(rdData), expRd());
    idle(1);
    sel = 0; rdEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog %s actual=hung expected=done", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    // R1: reset state
    tag = "R1";
    chk("rst_rd", int'(rdData), 0);
    chk("rst_irq", int'({irqAN, irqBN}), 3);
    chk("rst_en", int'({ca2OutEn, cb2OutEn}), 0);
    addr = 1; idle(1); addr = 3; idle(1);
    // R2 / R3: direction/data selection and mixed readback
    tag = "R2";
    busWr(0, 8'hF0); busRd(0); busWr(1, 8'h04); busWr(0, 8'h5A);
    tag = "R3";
    paIn = 8'h3C; busRd(0); paIn = 8'hC3; busRd(0);
    busWr(2, 8'h0F); busWr(3, 8'h04); busWr(2, 8'hA5); pbIn = 8'h96; busRd(2);
    tag = "R2";
    busWr(1, 8'h00); busRd(0); busWr(1, 8'h04);
    // R4: rising edge flag with interrupt
    tag = "R4";
    busWr(1, 8'h07); addr = 1;
    ca1 = 1; idle(2); busRd(1); ca1 = 0; idle(2);
    tag = "R6";
    busRd(0); busRd(1);
    tag = "R4";
    busWr(1, 8'h05); ca1 = 1; idle(2); addr = 1; ca1 = 0; idle(2); busRd(1);
    tag = "R7";
    busWr(1, 8'hC4); busRd(1); busRd(0);
    // R6: edge and data read in the same cycle
    tag = "R6";
    busWr(1, 8'h07);
    ca1 = 1; busRd(0); addr = 1; idle(1); busRd(0); addr = 1; idle(1);
    ca1 = 0; idle(1);
    // R5: port B second line as input
    tag = "R5";
    busWr(3, 8'h1C); addr = 3;
    cb2In = 1; idle(2); busRd(2); cb2In = 0; idle(2);
    busWr(3, 8'h0C); cb2In = 1; idle(2); cb2In = 0; idle(2); addr = 3; idle(1);
    tag = "R8";
    busWr(3, 8'h04); addr = 3; idle(1); busWr(3, 8'h0D); idle(1);
    cb1 = 1; idle(2); busWr(3, 8'h04); idle(1); busRd(2); cb1 = 0; idle(1);
    // R9: port A handshake, falling active edge
    tag = "R9";
    busWr(1, 8'h24); ca1 = 1; idle(2); ca1 = 0; idle(2);
    busWr(0, 8'h11); idle(1); busRd(0); idle(2);
    ca1 = 1; idle(1);
    ca1 = 0; busRd(0); idle(2);
    busRd(0); idle(1);
    // R10: port B handshake
    tag = "R10";
    busWr(3, 8'h24); cb1 = 1; idle(1); cb1 = 0; idle(2);
    busRd(2); idle(1); busWr(2, 8'h77); idle(2);
    // R11: pulse mode on both ports
    tag = "R11";
    busWr(1, 8'h2C); busRd(0); idle(3); busWr(0, 8'h01); idle(2);
    busWr(3, 8'h2C); busWr(2, 8'h33); idle(3); busRd(2); idle(2);
    busWr(2, 8'h34); busWr(2, 8'h35); idle(3);
    // R12: manual mode
    tag = "R12";
    busWr(1, 8'h38); idle(2); busWr(1, 8'h30); idle(2);
    busWr(3, 8'h3C); idle(1); busWr(3, 8'h1C); idle(2);
    tag = "R8";
    busWr(1, 8'h0D); ca2In = 1; idle(1); ca2In = 0; idle(2); busRd(0); idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule